// File: doc/BRIEF.md
# Register Write-Pending Scoreboard with Address-Operand Forwarding

This block sits at the decode stage of a processor front end whose general-purpose registers feed both address generation and fixed-point arithmetic. It keeps a small up/down count for every register. The count records how many decoded fixed-point instructions still owe that register a result. Decode raises the count for each register an issued instruction will write. The execution unit lowers it as each of those instructions completes. A decode that wants a register with a nonzero count as its base or index is held until the count returns to zero.

The front end can also change a register directly. Such a change reaches the register-file read port only after a fixed number of cycles. The block keeps the most recent changes in a short shift pipeline, and for each address operand it supplies the adder-output value in place of the stale register-file data while the change is in flight. Register 0 as base or index means "no register": it is never interlocked and its operand value is zero.

Top module: `gpr_scoreboard`

## Requirements
- R1: After reset every count is zero, so no base or index register causes a stall.
- R2: An issued instruction (dec_valid high and dec_stall low) adds one to the count of each destination field that is enabled. If both fields name the same register, that count rises by two.
- R3: While dec_valid is high, dec_stall is high if dec_base or dec_index names a nonzero register whose count is nonzero.
- R4: A completion (cmp_valid high) subtracts one from the count of each enabled completion field. If both fields name the same register, that count falls by two.
- R5: If an increment and a decrement reach the same register in the same cycle, its count is left unchanged.
- R6: Counts are CNT_W bits wide (3 by default, maximum 7). Decode stalls an instruction whose increments would push any count past the maximum. The test uses the count before any same-cycle completion. A stalled instruction changes no count.
- R7: Register 0 named as base or index never causes a stall, and its operand output is zero. A write to register 0 as a destination is still counted.
- R8: A front-end register change presented with iu_wr_en in cycle t is returned on agen_base or agen_index in cycles t+1 through t+BYP_STAGES when that register is read. When two changes to the same register are in flight, the younger one wins.
- R9: In cycle t itself, and from cycle t+BYP_STAGES+1 onward, the operand outputs carry the register-file read data.
- R10: With dec_valid low, dec_stall is low and no count changes because of decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is present at decode |
| dec_dst0_en | input | 1 | First destination field is used |
| dec_dst0 | input | IDX_W | First destination register |
| dec_dst1_en | input | 1 | Second destination field is used |
| dec_dst1 | input | IDX_W | Second destination register |
| dec_base | input | IDX_W | Base register for address generation (0 = none) |
| dec_index | input | IDX_W | Index register for address generation (0 = none) |
| dec_stall | output | 1 | Decode must hold this instruction |
| cmp_valid | input | 1 | Execution unit completes an instruction |
| cmp_dst0_en | input | 1 | First completion field is used |
| cmp_dst0 | input | IDX_W | First completed destination |
| cmp_dst1_en | input | 1 | Second completion field is used |
| cmp_dst1 | input | IDX_W | Second completed destination |
| iu_wr_en | input | 1 | Front end changes a register this cycle |
| iu_wr_idx | input | IDX_W | Register the front end changes |
| iu_wr_data | input | DATA_W | Adder-output value written |
| rf_base_data | input | DATA_W | Register-file data read for dec_base |
| rf_index_data | input | DATA_W | Register-file data read for dec_index |
| agen_base | output | DATA_W | Base operand delivered to address generation |
| agen_index | output | DATA_W | Index operand delivered to address generation |

## Verification
The bench uses the defaults: 16 registers, 3-bit counts, 32-bit data and a two-stage forwarding window. With 3-bit counts, saturation comes after only seven writers to one register, so the overflow stall and its recovery are exercised directly. With two stages, the whole forwarding window fits in a few cycles: the stale value in the write cycle, forwarding from the younger and older stages, and the return to register-file data. Four registers (0, 5, 8 and 9) cover register 0, saturation, a same-cycle increment and decrement, and double counting from two equal destination fields.

// File: rtl/gpr_scb_pkg.sv
package gpr_scb_pkg;

   // Number of enabled fields (0..2) that name register r.
   function automatic logic [1:0] field_hits(input logic en0, input int unsigned idx0,
                                             input logic en1, input int unsigned idx1,
                                             input int unsigned r);
      logic [1:0] h;
      h = 2'd0;
      if (en0 && idx0 == r) h = h + 2'd1;
      if (en1 && idx1 == r) h = h + 2'd1;
      return h;
   endfunction

endpackage

// File: rtl/gpr_scb_counter.sv
module gpr_scb_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       inc,
   input  logic [1:0]       dec,
   output logic [CNT_W-1:0] cnt
);
   localparam int PAD_W = CNT_W - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   sum;

   always_comb begin
      sum = {1'b0, cnt_q} + {{PAD_W{1'b0}}, inc} - {{PAD_W{1'b0}}, dec};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= sum[CNT_W-1:0];
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/gpr_scb_fwd_pipe.sv
module gpr_scb_fwd_pipe #(
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [STAGES-1:0]          stg_vld,
   output logic [STAGES*IDX_W-1:0]    stg_idx,
   output logic [STAGES*DATA_W-1:0]   stg_data
);
   // Stage 0 holds the youngest change.
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic              vld_q;
      logic [IDX_W-1:0]  idx_q;
      logic [DATA_W-1:0] data_q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= wr_en;
            idx_q  <= wr_idx;
            data_q <= wr_data;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= g_stage[s-1].vld_q;
            idx_q  <= g_stage[s-1].idx_q;
            data_q <= g_stage[s-1].data_q;
         end
      end
      assign stg_vld[s]                     = vld_q;
      assign stg_idx[s*IDX_W +: IDX_W]      = idx_q;
      assign stg_data[s*DATA_W +: DATA_W]   = data_q;
   end
endmodule

// File: rtl/gpr_scb_fwd_sel.sv
module gpr_scb_fwd_sel #(
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic [STAGES-1:0]        stg_vld,
   input  logic [STAGES*IDX_W-1:0]  stg_idx,
   input  logic [STAGES*DATA_W-1:0] stg_data,
   input  logic [IDX_W-1:0]         rd_idx,
   input  logic [DATA_W-1:0]        rf_data,
   output logic [DATA_W-1:0]        rd_data
);
   always_comb begin
      rd_data = rf_data;
      // Oldest first so the youngest matching stage overrides.
      for (int s = STAGES - 1; s >= 0; s--) begin
         if (stg_vld[s] && stg_idx[s*IDX_W +: IDX_W] == rd_idx)
            rd_data = stg_data[s*DATA_W +: DATA_W];
      end
      if (rd_idx == '0) rd_data = '0;
   end
endmodule

// File: rtl/gpr_scoreboard.sv
module gpr_scoreboard #(
   parameter int NUM_REGS   = 16,
   parameter int CNT_W      = 3,
   parameter int DATA_W     = 32,
   parameter int BYP_STAGES = 2,
   parameter int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   input  logic              dec_dst0_en,
   input  logic [IDX_W-1:0]  dec_dst0,
   input  logic              dec_dst1_en,
   input  logic [IDX_W-1:0]  dec_dst1,
   input  logic [IDX_W-1:0]  dec_base,
   input  logic [IDX_W-1:0]  dec_index,
   output logic              dec_stall,
   input  logic              cmp_valid,
   input  logic              cmp_dst0_en,
   input  logic [IDX_W-1:0]  cmp_dst0,
   input  logic              cmp_dst1_en,
   input  logic [IDX_W-1:0]  cmp_dst1,
   input  logic              iu_wr_en,
   input  logic [IDX_W-1:0]  iu_wr_idx,
   input  logic [DATA_W-1:0] iu_wr_data,
   input  logic [DATA_W-1:0] rf_base_data,
   input  logic [DATA_W-1:0] rf_index_data,
   output logic [DATA_W-1:0] agen_base,
   output logic [DATA_W-1:0] agen_index
);
   import gpr_scb_pkg::*;

   localparam int               PAD_W   = CNT_W - 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // Elaboration-time parameter checks.
   if (NUM_REGS < 2 || NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (BYP_STAGES < 1) begin : g_bad_byp
      $error("BYP_STAGES must be at least 1");
   end

   logic [NUM_REGS*CNT_W-1:0] cnt_flat;
   logic [NUM_REGS-1:0]       ovf;
   logic                      issue;
   logic                      base_busy, index_busy;

   // ---------------- per-register counters ----------------
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [1:0]       raw_inc, inc, dec;
      logic [CNT_W-1:0] cnt;
      assign raw_inc = field_hits(dec_dst0_en, int'(dec_dst0), dec_dst1_en, int'(dec_dst1), r);
      assign inc     = issue ? raw_inc : 2'd0;
      assign dec     = cmp_valid ? field_hits(cmp_dst0_en, int'(cmp_dst0),
                                              cmp_dst1_en, int'(cmp_dst1), r) : 2'd0;
      assign ovf[r]  = ({1'b0, cnt} + {{PAD_W{1'b0}}, raw_inc}) > {1'b0, CNT_MAX};

      gpr_scb_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc),
         .dec   (dec),
         .cnt   (cnt)
      );
      assign cnt_flat[r*CNT_W +: CNT_W] = cnt;
   end

   // ---------------- interlock ----------------
   assign base_busy  = (dec_base  != '0) && (cnt_flat[dec_base  * CNT_W +: CNT_W] != '0);
   assign index_busy = (dec_index != '0) && (cnt_flat[dec_index * CNT_W +: CNT_W] != '0);
   assign dec_stall  = dec_valid && (base_busy || index_busy || (|ovf));
   assign issue      = dec_valid && !dec_stall;

   // ---------------- forwarding ----------------
   logic [BYP_STAGES-1:0]        stg_vld;
   logic [BYP_STAGES*IDX_W-1:0]  stg_idx;
   logic [BYP_STAGES*DATA_W-1:0] stg_data;

   gpr_scb_fwd_pipe #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STAGES(BYP_STAGES)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (iu_wr_en),
      .wr_idx   (iu_wr_idx),
      .wr_data  (iu_wr_data),
      .stg_vld  (stg_vld),
      .stg_idx  (stg_idx),
      .stg_data (stg_data)
   );

   gpr_scb_fwd_sel #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STAGES(BYP_STAGES)) u_sel_base (
      .stg_vld  (stg_vld),
      .stg_idx  (stg_idx),
      .stg_data (stg_data),
      .rd_idx   (dec_base),
      .rf_data  (rf_base_data),
      .rd_data  (agen_base)
   );

   gpr_scb_fwd_sel #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STAGES(BYP_STAGES)) u_sel_index (
      .stg_vld  (stg_vld),
      .stg_idx  (stg_idx),
      .stg_data (stg_data),
      .rd_idx   (dec_index),
      .rf_data  (rf_index_data),
      .rd_data  (agen_index)
   );
endmodule

// File: rtl/gpr_scoreboard_chk.sv
module gpr_scoreboard_chk #(
   parameter int NUM_REGS = 16,
   parameter int CNT_W    = 3,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      dec_valid,
   input logic                      dec_dst0_en,
   input logic [IDX_W-1:0]          dec_dst0,
   input logic [IDX_W-1:0]          dec_base,
   input logic [IDX_W-1:0]          dec_index,
   input logic                      dec_stall,
   input logic                      cmp_valid,
   input logic                      cmp_dst0_en,
   input logic [IDX_W-1:0]          cmp_dst0,
   input logic                      iu_wr_en,
   input logic [IDX_W-1:0]          iu_wr_idx,
   input logic [DATA_W-1:0]         iu_wr_data,
   input logic [DATA_W-1:0]         agen_base,
   input logic [DATA_W-1:0]         agen_index,
   input logic [NUM_REGS*CNT_W-1:0] cnt_flat
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_stall);

   p_hold_busy_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_base != '0 && cnt_flat[dec_base*CNT_W +: CNT_W] != '0) |-> dec_stall);

   p_hold_busy_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_index != '0 && cnt_flat[dec_index*CNT_W +: CNT_W] != '0) |-> dec_stall);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_stall && dec_dst0_en) |-> cnt_flat[dec_dst0*CNT_W +: CNT_W] != CNT_MAX);

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_dst0_en) |-> cnt_flat[cmp_dst0*CNT_W +: CNT_W] != '0);

   p_zero_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_base == '0) |-> (agen_base == '0));

   p_zero_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_index == '0) |-> (agen_index == '0));

   p_fwd_young_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(iu_wr_en) && dec_base != '0 && dec_base == $past(iu_wr_idx))
      |-> agen_base == $past(iu_wr_data));
endmodule

bind gpr_scoreboard gpr_scoreboard_chk #(
   .NUM_REGS (NUM_REGS),
   .CNT_W    (CNT_W),
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid),
   .dec_dst0_en (dec_dst0_en),
   .dec_dst0    (dec_dst0),
   .dec_base    (dec_base),
   .dec_index   (dec_index),
   .dec_stall   (dec_stall),
   .cmp_valid   (cmp_valid),
   .cmp_dst0_en (cmp_dst0_en),
   .cmp_dst0    (cmp_dst0),
   .iu_wr_en    (iu_wr_en),
   .iu_wr_idx   (iu_wr_idx),
   .iu_wr_data  (iu_wr_data),
   .agen_base   (agen_base),
   .agen_index  (agen_index),
   .cnt_flat    (cnt_flat)
);

// File: tb/gpr_scoreboard_tb.sv
module gpr_scoreboard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 17;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dec_valid, dec_dst0_en, dec_dst1_en;
   logic [3:0]  dec_dst0, dec_dst1, dec_base, dec_index;
   logic        dec_stall;
   logic        cmp_valid, cmp_dst0_en, cmp_dst1_en;
   logic [3:0]  cmp_dst0, cmp_dst1;
   logic        iu_wr_en;
   logic [3:0]  iu_wr_idx;
   logic [31:0] iu_wr_data, rf_base_data, rf_index_data, agen_base, agen_index;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpr_scoreboard u_dut (
      .clk(clk), .rst_n(rst_n),
      .dec_valid(dec_valid), .dec_dst0_en(dec_dst0_en), .dec_dst0(dec_dst0),
      .dec_dst1_en(dec_dst1_en), .dec_dst1(dec_dst1),
      .dec_base(dec_base), .dec_index(dec_index), .dec_stall(dec_stall),
      .cmp_valid(cmp_valid), .cmp_dst0_en(cmp_dst0_en), .cmp_dst0(cmp_dst0),
      .cmp_dst1_en(cmp_dst1_en), .cmp_dst1(cmp_dst1),
      .iu_wr_en(iu_wr_en), .iu_wr_idx(iu_wr_idx), .iu_wr_data(iu_wr_data),
      .rf_base_data(rf_base_data), .rf_index_data(rf_index_data),
      .agen_base(agen_base), .agen_index(agen_index)
   );

   // Vector layout: [30] dv [29] d0e [28:25] d0 [24] d1e [23:20] d1 [19:16] base
   // [15:12] index [11] cv [10] c0e [9:6] c0 [5] c1e [4:1] c1 [0] expected stall
   localparam logic [30:0] VEC [NV] = '{
      {1'b1,1'b1,4'd3,1'b0,4'd0,4'd0,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R2 r3 +1
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd3,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b1}, // R3 base busy
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd0,4'd3, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b1}, // R3 index busy
      {1'b1,1'b1,4'd3,1'b0,4'd0,4'd5,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R2 r3 -> 2
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd3,4'd0, 1'b1,1'b1,4'd3,1'b0,4'd0, 1'b1}, // R4 r3 -> 1
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd3,4'd0, 1'b1,1'b1,4'd3,1'b0,4'd0, 1'b1}, // R4 r3 -> 0
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd3,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R4 freed
      {1'b1,1'b1,4'd7,1'b1,4'd8,4'd0,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R2 two dsts
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd0,4'd8, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b1}, // R3 r8 busy
      {1'b1,1'b1,4'd8,1'b0,4'd0,4'd0,4'd0, 1'b1,1'b1,4'd7,1'b1,4'd8, 1'b0}, // R5 inc+dec r8
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd7,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R4 r7 free
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd8,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b1}, // R5 r8 still 1
      {1'b0,1'b0,4'd0,1'b0,4'd0,4'd8,4'd0, 1'b1,1'b1,4'd8,1'b0,4'd0, 1'b0}, // R10 idle
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd8,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R4 r8 free
      {1'b1,1'b1,4'd0,1'b0,4'd0,4'd0,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R7 r0 counted
      {1'b1,1'b0,4'd0,1'b0,4'd0,4'd0,4'd0, 1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0}, // R7 r0 no hold
      {1'b0,1'b0,4'd0,1'b0,4'd0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b0,4'd0, 1'b0}  // R4 drain r0
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      dec_valid = 0; dec_dst0_en = 0; dec_dst0 = 0; dec_dst1_en = 0; dec_dst1 = 0;
      dec_base = 0; dec_index = 0;
      cmp_valid = 0; cmp_dst0_en = 0; cmp_dst0 = 0; cmp_dst1_en = 0; cmp_dst1 = 0;
      iu_wr_en = 0; iu_wr_idx = 0; iu_wr_data = 0;
   endtask

   // One decode cycle: drive after the falling edge, sample the stall, let the rising edge act.
   task automatic dec_cycle(input logic dv, input logic [3:0] d0, input logic d0e,
                            input logic [3:0] d1, input logic d1e, input logic [3:0] base,
                            input logic cv, input logic [3:0] c0, input logic c0e,
                            input logic exp_stall, input string req);
      @(negedge clk);
      idle();
      dec_valid = dv; dec_dst0 = d0; dec_dst0_en = d0e; dec_dst1 = d1; dec_dst1_en = d1e;
      dec_base = base; cmp_valid = cv; cmp_dst0 = c0; cmp_dst0_en = c0e;
      #1 check({31'd0, dec_stall}, {31'd0, exp_stall}, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      idle();
      rf_base_data  = 32'hAAAA_0001;
      rf_index_data = 32'hBBBB_0002;
      rst_n = 0;
      do_reset();

      // R1: no register busy after reset
      for (int r = 1; r < 16; r++) begin
         dec_cycle(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'(r), 1'b0, 4'd0, 1'b0, 1'b0, "R1 reset state");
      end

      // Table walk: R2 R3 R4 R5 R7 R10
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         idle();
         {dec_valid, dec_dst0_en, dec_dst0, dec_dst1_en, dec_dst1, dec_base, dec_index,
          cmp_valid, cmp_dst0_en, cmp_dst0, cmp_dst1_en, cmp_dst1} = VEC[i][30:1];
         #1 check({31'd0, dec_stall}, {31'd0, VEC[i][0]}, $sformatf("R2/R3/R4/R5 vector %0d", i));
      end

      // R10: invalid decode with a destination leaves r11 untouched
      dec_cycle(1'b0, 4'd11, 1'b1, 4'd0, 1'b0, 4'd11, 1'b0, 4'd0, 1'b0, 1'b0, "R10 idle stall");
      dec_cycle(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd11, 1'b0, 4'd0, 1'b0, 1'b0, "R10 no increment");

      // R6: saturate r5 at seven writers
      for (int k = 0; k < 7; k++) begin
         dec_cycle(1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, "R6 fill");
      end
      dec_cycle(1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, "R6 overflow stall");
      dec_cycle(1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 4'd5, 1'b1, 1'b1, "R6 pre-completion count");
      // count now 6: one more writer allowed, then full again
      dec_cycle(1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, "R6 room after completion");
      dec_cycle(1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, "R6 full again");
      for (int k = 0; k < 7; k++) begin
         dec_cycle(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd5, 1'b1, 1'b0, "R4 drain");
      end
      dec_cycle(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd5, 1'b0, 4'd0, 1'b0, 1'b0, "R6 drained");

      // R2/R4: both destinations name r9
      dec_cycle(1'b1, 4'd9, 1'b1, 4'd9, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, "R2 double dst");
      dec_cycle(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd9, 1'b1, 1'b0, "R4 one of two");
      dec_cycle(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9, 1'b0, 4'd0, 1'b0, 1'b1, "R2 r9 still busy");
      dec_cycle(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd9, 1'b1, 1'b0, "R4 second");
      dec_cycle(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9, 1'b0, 4'd0, 1'b0, 1'b0, "R4 r9 free");

      // R1: reset mid-run clears a busy count
      dec_cycle(1'b1, 4'd6, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, "R2 r6");
      do_reset();
      dec_cycle(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd6, 1'b0, 4'd0, 1'b0, 1'b0, "R1 reset clears");

      // R8/R9: forwarding window on base
      @(negedge clk); idle();
      dec_base = 4'd4; dec_index = 4'd2;
      iu_wr_en = 1; iu_wr_idx = 4'd4; iu_wr_data = 32'h1111_0004;
      #1 check(agen_base, 32'hAAAA_0001, "R9 write cycle stale");
      @(negedge clk); iu_wr_en = 0;
      #1 check(agen_base, 32'h1111_0004, "R8 window cycle 1");
      check(agen_index, 32'hBBBB_0002, "R9 other reg passthrough");
      @(negedge clk);
      #1 check(agen_base, 32'h1111_0004, "R8 window cycle 2");
      @(negedge clk);
      #1 check(agen_base, 32'hAAAA_0001, "R9 after window");

      // R8: two changes in flight, younger wins; index path
      @(negedge clk); idle();
      dec_index = 4'd4; dec_base = 4'd0;
      iu_wr_en = 1; iu_wr_idx = 4'd4; iu_wr_data = 32'h2222_0004;
      @(negedge clk);
      iu_wr_data = 32'h3333_0004;
      #1 check(agen_index, 32'h2222_0004, "R8 first change");
      check(agen_base, 32'h0, "R7 base zero operand");
      @(negedge clk); iu_wr_en = 0;
      #1 check(agen_index, 32'h3333_0004, "R8 younger wins");
      @(negedge clk);
      #1 check(agen_index, 32'h3333_0004, "R8 younger older stage");
      @(negedge clk);
      #1 check(agen_index, 32'hBBBB_0002, "R9 index after window");

      // R7: change to r0 is never forwarded
      @(negedge clk); idle();
      iu_wr_en = 1; iu_wr_idx = 4'd0; iu_wr_data = 32'h4444_0000;
      @(negedge clk); iu_wr_en = 0;
      #1 check(agen_base, 32'h0, "R7 r0 not forwarded");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule